// File: doc/BRIEF.md
# Tapped Timer with Watchdog

This block is a free-running binary counter advanced by a main-clock enable. Software-side logic reaches it through three strobes: a write of a 4-bit control word, a clear, and a read that captures a 4-bit nibble. The nibble always carries inverted counter bits, so a freshly reset counter reads as all ones. A wide mode exposes four high-order bits. A narrow mode exposes a single tap, picked by a 3-bit field, on the top bit of the nibble.

The selected tap is also driven as a live output. Some encodings widen its high phase from half to three quarters of the period. The same counter serves as a watchdog. When the watchdog is enabled and the counter goes 2^16 ticks without a clear, the block emits a one-clock reset pulse and restarts the count from zero. A wake-from-hold strobe clears the counter exactly as the clear strobe does.

Top module: `tmrw_top`

## Requirements
- R1: The counter advances by one on each clock edge where `tick_en` is 1, and holds its value when `tick_en` is 0.
- R2: After reset, `rd_data` is 4'b1111, `tap_out` is 0, `wdog_rst_o` is 0, and the control word is 4'b1000 (wide mode, tap select 000).
- R3: A `clr_i` strobe sets every counter bit to zero at the next edge.
- R4: A `wake_i` strobe (release from hold) sets every counter bit to zero at the next edge.
- R5: When control bit 3 is 1 (wide mode), a read returns the complement of counter bits 14, 13, 12 and 11 on nibble bits 3, 2, 1 and 0. These are the taps of period 2^15, 2^14, 2^13 and 2^12 ticks.
- R6: When control bit 3 is 0 (narrow mode), a read returns the complement of the selected tap on nibble bit 3, and zeros on bits 2..0.
- R7: Control bits 2..0 select `tap_out`. The encodings are: 000 = counter bit 9, 001 = bit 10, 010 = bit 10 OR bit 9, 011 = bit 11, 100 = bit 11 OR bit 10, 101 = bit 12, 110 = bit 12 OR bit 11, 111 = bit 13. The OR forms give a 75% high duty; the others give 50%.
- R8: With `wdog_en` at 1, a tick that finds the counter at 2^16-1 makes `wdog_rst_o` high for exactly one clock and returns the counter to zero.
- R9: With `wdog_en` at 0, `wdog_rst_o` stays 0 and the counter runs past 2^16-1.
- R10: `rd_data` loads only on an edge where `rd_en` is 1, and holds otherwise. A read uses the control word in force before that edge. A `ctl_we` write takes effect at its edge.
- R11: A clear or wake strobe takes precedence over a same-cycle tick, and suppresses a watchdog pulse in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Main-clock enable; one count per high cycle |
| clr_i | input | 1 | Clear strobe |
| wake_i | input | 1 | Release-from-hold strobe; clears the counter |
| wdog_en | input | 1 | Enables the watchdog function |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: bit 3 mode, bits 2..0 tap select |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 4 | Captured read nibble |
| tap_out | output | 1 | Live selected tap |
| wdog_rst_o | output | 1 | One-clock watchdog reset pulse |

## Verification
Reset release passes through a two-stage synchronizer, so the first edge that acts on inputs is the third rising edge after `rst_n` goes high. The bench holds every strobe idle until then. The counter and the watchdog pulse are registered. As a result, `tap_out` and `wdog_rst_o` reflect a stimulus at the first edge after it, and `rd_data` shows a read one edge after `rd_en`, built from the pre-edge counter and control word. The bench drives inputs on the falling edge and advances its model by exactly one edge. It compares all three outputs at the next falling edge, so every expected value lines up with the register that produces it.

// File: rtl/tmrw_pkg.sv
package tmrw_pkg;

  localparam int SEL_W = 3;
  localparam int SEL_N = 1 << SEL_W;
  localparam int NIB_W = 4;

  // Offset of the tap's high bit above the shortest tap, per select code.
  function automatic int tap_offset(input int sel);
    return (sel + 1) / 2;
  endfunction

  // Three-quarter duty codes: even and non-zero.
  function automatic bit tap_wide(input int sel);
    return (sel != 0) && ((sel % 2) == 0);
  endfunction

endpackage

// File: rtl/tmrw_rst_sync.sv
module tmrw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/tmrw_counter.sv
module tmrw_counter #(
  parameter int CNT_W    = 17,
  parameter int WDOG_EXP = 16,
  parameter int WIN_LO   = 9,
  parameter int WIN_HI   = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic                   clr_i,
  input  logic                   wake_i,
  input  logic                   wdog_en,
  output logic [WIN_HI-WIN_LO:0] cnt_win,
  output logic                   wdog_fire
);

  localparam logic [CNT_W-1:0] WD_LAST =
    {{(CNT_W-WDOG_EXP){1'b0}}, {WDOG_EXP{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             fire_q;
  logic             fire_d;

  always_comb begin
    fire_d = wdog_en & tick_en & ~clr_i & ~wake_i & (cnt_q == WD_LAST);
    cnt_d  = cnt_q;
    if (clr_i || wake_i || fire_d) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign cnt_win   = cnt_q[WIN_HI:WIN_LO];
  assign wdog_fire = fire_q;

endmodule

// File: rtl/tmrw_tap_mux.sv
module tmrw_tap_mux #(
  parameter int TAP_W = 5
) (
  input  logic [TAP_W-1:0]            taps,
  input  logic [tmrw_pkg::SEL_W-1:0]  sel,
  output logic                        tap
);

  import tmrw_pkg::*;

  logic [SEL_N-1:0] opt;

  for (genvar s = 0; s < SEL_N; s++) begin : g_opt
    localparam int HI = tap_offset(s);
    if (tap_wide(s)) begin : g_wide
      assign opt[s] = taps[HI] | taps[HI-1];
    end else begin : g_half
      assign opt[s] = taps[HI];
    end
  end

  assign tap = opt[sel];

endmodule

// File: rtl/tmrw_readout.sv
module tmrw_readout (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic                        wide_mode,
  input  logic                        tap,
  input  logic [tmrw_pkg::NIB_W-1:0]  raw,
  output logic [tmrw_pkg::NIB_W-1:0]  rd_data
);

  import tmrw_pkg::*;

  logic [NIB_W-1:0] nib_d;
  logic [NIB_W-1:0] rd_q;
  logic [NIB_W-1:0] rd_d;

  always_comb begin
    if (wide_mode) begin
      nib_d = ~raw;
    end else begin
      nib_d = {~tap, {(NIB_W-1){1'b0}}};
    end
    rd_d = rd_en ? nib_d : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '1;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/tmrw_top.sv
module tmrw_top #(
  parameter int CNT_W       = 17,
  parameter int WDOG_EXP    = 16,
  parameter int TAP_EXP_MIN = 10,
  parameter int RAW_EXP_LO  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       clr_i,
  input  logic       wake_i,
  input  logic       wdog_en,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wdata,
  input  logic       rd_en,
  output logic [3:0] rd_data,
  output logic       tap_out,
  output logic       wdog_rst_o
);

  import tmrw_pkg::*;

  localparam int TAP_BIT0 = TAP_EXP_MIN - 1;
  localparam int TAP_HI   = TAP_BIT0 + tap_offset(SEL_N - 1);
  localparam int TAP_W    = TAP_HI - TAP_BIT0 + 1;
  localparam int RAW_LO   = RAW_EXP_LO - 1;
  localparam int RAW_HI   = RAW_LO + NIB_W - 1;
  localparam int WIN_LO   = (TAP_BIT0 < RAW_LO) ? TAP_BIT0 : RAW_LO;
  localparam int WIN_HI   = (TAP_HI > RAW_HI) ? TAP_HI : RAW_HI;
  localparam int WIN_W    = WIN_HI - WIN_LO + 1;
  localparam logic [NIB_W-1:0] CTL_RST = {1'b1, {SEL_W{1'b0}}};

  logic             rst_sync_n;
  logic [WIN_W-1:0] cnt_win;
  logic [NIB_W-1:0] ctl_q;
  logic [NIB_W-1:0] ctl_d;
  logic             tap_sel;

  tmrw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tmrw_counter #(
    .CNT_W    (CNT_W),
    .WDOG_EXP (WDOG_EXP),
    .WIN_LO   (WIN_LO),
    .WIN_HI   (WIN_HI)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_en   (tick_en),
    .clr_i     (clr_i),
    .wake_i    (wake_i),
    .wdog_en   (wdog_en),
    .cnt_win   (cnt_win),
    .wdog_fire (wdog_rst_o)
  );

  always_comb begin
    ctl_d = ctl_we ? ctl_wdata : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q <= CTL_RST;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  tmrw_tap_mux #(
    .TAP_W (TAP_W)
  ) u_tap (
    .taps (cnt_win[TAP_HI-WIN_LO:TAP_BIT0-WIN_LO]),
    .sel  (ctl_q[SEL_W-1:0]),
    .tap  (tap_sel)
  );

  tmrw_readout u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_en     (rd_en),
    .wide_mode (ctl_q[NIB_W-1]),
    .tap       (tap_sel),
    .raw       (cnt_win[RAW_HI-WIN_LO:RAW_LO-WIN_LO]),
    .rd_data   (rd_data)
  );

  assign tap_out = tap_sel;

endmodule

// File: rtl/tmrw_chk.sv
module tmrw_chk #(
  parameter int WIN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             clr_i,
  input logic             wake_i,
  input logic             wdog_en,
  input logic             rd_en,
  input logic [3:0]       rd_data,
  input logic             tap_out,
  input logic             wdog_rst_o,
  input logic [3:0]       ctl,
  input logic [WIN_W-1:0] win
);

  a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr_i && !wake_i) |=> $stable(win));

  a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (win == '0) && !tap_out);

  a_r4_wake_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> (win == '0));

  a_r6_narrow_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ctl[3]) |=> (rd_data[2:0] == 3'b000));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |=> !wdog_rst_o);

  a_r8_pulse_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> (win == '0));

  a_r9_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_en |=> !wdog_rst_o);

  a_r10_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  a_r11_clear_beats_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || wake_i) |=> !wdog_rst_o);

endmodule

bind tmrw_top tmrw_chk #(
  .WIN_W (WIN_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick_en    (tick_en),
  .clr_i      (clr_i),
  .wake_i     (wake_i),
  .wdog_en    (wdog_en),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .tap_out    (tap_out),
  .wdog_rst_o (wdog_rst_o),
  .ctl        (ctl_q),
  .win        (cnt_win)
);

// File: tb/tmrw_top_tb_top.sv
module tmrw_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, clr_i, wake_i, wdog_en, ctl_we, rd_en;
  logic [3:0] ctl_wdata;
  logic [3:0] rd_data;
  logic       tap_out, wdog_rst_o;

  always #5 clk = ~clk;

  tmrw_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr_i(clr_i),
    .wake_i(wake_i), .wdog_en(wdog_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .rd_en(rd_en), .rd_data(rd_data),
    .tap_out(tap_out), .wdog_rst_o(wdog_rst_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_pulse = 0;

  logic [16:0] m_cnt;
  logic [3:0]  m_ctl, m_rd;
  logic        m_wd;

  // R7 table
  function automatic logic f_tap(logic [16:0] c, logic [2:0] s);
    case (s)
      3'd0: return c[9];
      3'd1: return c[10];
      3'd2: return c[10] | c[9];
      3'd3: return c[11];
      3'd4: return c[11] | c[10];
      3'd5: return c[12];
      3'd6: return c[12] | c[11];
      default: return c[13];
    endcase
  endfunction

  // R5 / R6 nibble
  function automatic logic [3:0] f_nib(logic [16:0] c, logic [3:0] k);
    if (k[3]) return ~c[14:11];
    return {~f_tap(c, k[2:0]), 3'b000};
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic        fire;
    logic [16:0] ncnt;
    logic [3:0]  nrd, nctl;
    fire = wdog_en & tick_en & ~clr_i & ~wake_i & (m_cnt == 17'h0FFFF);
    if (clr_i || wake_i || fire) ncnt = '0;
    else if (tick_en)            ncnt = m_cnt + 17'd1;
    else                         ncnt = m_cnt;
    nrd  = rd_en ? f_nib(m_cnt, m_ctl) : m_rd;
    nctl = ctl_we ? ctl_wdata : m_ctl;
    @(posedge clk);
    @(negedge clk);
    m_cnt = ncnt; m_rd = nrd; m_ctl = nctl; m_wd = fire;
    if (wdog_rst_o === 1'b1) n_pulse++;
    chk("R7 tap_out", {3'b0, tap_out}, {3'b0, f_tap(m_cnt, m_ctl[2:0])});
    chk("R8 wdog_rst_o", {3'b0, wdog_rst_o}, {3'b0, m_wd});
    chk("R10 rd_data", rd_data, m_rd);
  endtask

  task automatic ticks(int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) cyc();
    tick_en = 1'b0;
  endtask

  task automatic wr_ctl(logic [3:0] v);
    ctl_we = 1'b1; ctl_wdata = v; cyc(); ctl_we = 1'b0;
  endtask

  task automatic do_rd();
    rd_en = 1'b1; cyc(); rd_en = 1'b0;
  endtask

  task automatic do_clr();
    clr_i = 1'b1; cyc(); clr_i = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_en = 1'b0; clr_i = 1'b0; wake_i = 1'b0;
    wdog_en = 1'b0; ctl_we = 1'b0; ctl_wdata = 4'h0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_cnt = '0; m_ctl = 4'b1000; m_rd = 4'hF; m_wd = 1'b0;

    // R2 reset state
    chk("R2 rd_data", rd_data, 4'hF);
    chk("R2 tap_out", {3'b0, tap_out}, 4'h0);
    chk("R2 wdog_rst_o", {3'b0, wdog_rst_o}, 4'h0);
    do_rd();
    chk("R2 first read all ones", rd_data, 4'hF);

    // R1 / R5: 0x1800 ticks -> bits 12,11 set, wide read = ~0011 = 1100
    ticks(32'h1800);
    do_rd();
    chk("R5 wide read", rd_data, 4'hC);
    // R1: no ticks, value held
    repeat (20) cyc();
    do_rd();
    chk("R1 hold without tick", rd_data, 4'hC);

    // R6 narrow mode: sel 000 -> bit9=0 -> 1000 ; sel 011 -> bit11=1 -> 0000
    wr_ctl(4'b0000);
    do_rd();
    chk("R6 narrow sel0", rd_data, 4'h8);
    wr_ctl(4'b0011);
    do_rd();
    chk("R6 narrow sel3", rd_data, 4'h0);

    // R10: control write without read leaves rd_data
    wr_ctl(4'b1000);
    cyc();
    chk("R10 hold after ctl write", rd_data, 4'h0);
    // R10: read and write same edge uses old control (narrow sel3 -> 0000)
    wr_ctl(4'b0011);
    rd_en = 1'b1; ctl_we = 1'b1; ctl_wdata = 4'b1000; cyc();
    rd_en = 1'b0; ctl_we = 1'b0;
    chk("R10 read uses old ctl", rd_data, 4'h0);

    // R3 / R11: clear with tick in same cycle -> zero
    tick_en = 1'b1; clr_i = 1'b1; cyc(); clr_i = 1'b0; tick_en = 1'b0;
    do_rd();
    chk("R3 R11 clear beats tick", rd_data, 4'hF);

    // R7 duty: count 0x200 -> bit9=1, bit10=0
    ticks(32'h200);
    wr_ctl(4'b0001);
    chk("R7 sel1 bit10", {3'b0, tap_out}, 4'h0);
    wr_ctl(4'b0010);
    chk("R7 sel2 wide duty", {3'b0, tap_out}, 4'h1);
    wr_ctl(4'b0000);
    chk("R7 sel0 bit9", {3'b0, tap_out}, 4'h1);

    // R4 wake clears
    wake_i = 1'b1; cyc(); wake_i = 1'b0;
    chk("R4 wake clears tap", {3'b0, tap_out}, 4'h0);

    // Random phase
    wdog_en = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      tick_en   = ($urandom % 10) != 0;
      clr_i     = ($urandom % 200) == 0;
      wake_i    = ($urandom % 300) == 0;
      rd_en     = ($urandom % 5) == 0;
      ctl_we    = ($urandom % 40) == 0;
      ctl_wdata = 4'($urandom);
      cyc();
    end
    tick_en = 1'b0; clr_i = 1'b0; wake_i = 1'b0; rd_en = 1'b0; ctl_we = 1'b0;

    // R9: disabled, counter passes the limit without a pulse
    wdog_en = 1'b0;
    do_clr();
    n_pulse = 0;
    ticks(65540);
    chk("R9 no pulse when disabled", 4'(n_pulse), 4'h0);
    wr_ctl(4'b1000);
    do_rd();
    chk("R9 counter kept running", rd_data, 4'hF);

    // R8: enabled, pulse on the 2^16-th tick
    wdog_en = 1'b1;
    do_clr();
    n_pulse = 0;
    ticks(65535);
    chk("R8 no early pulse", 4'(n_pulse), 4'h0);
    tick_en = 1'b1; cyc(); tick_en = 1'b0;
    chk("R8 pulse at expiry", {3'b0, wdog_rst_o}, 4'h1);
    cyc();
    chk("R8 pulse one clock", {3'b0, wdog_rst_o}, 4'h0);
    do_rd();
    chk("R8 counter restarted", rd_data, 4'hF);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule